// File: doc/BRIEF.md
# MDIO Management Slave Registers

This block is the management side of a Fast Ethernet physical-layer device. It listens to the two-wire serial management bus, using MDC as its clock. MDIO is bidirectional and is split here into an input, an output and an output enable. A master addresses the device with frames made of these fields in order: a run of ones, a start code, an opcode, a PHY address, a register address, a two-bit turnaround and a sixteen-bit data word. The slave answers only when the PHY address in the frame equals its five-bit strap.

The block holds two registers. Register 0 is the control register. Its bits drive the loopback, power-down, isolate, duplex and collision-test outputs, and it has a self-clearing reset bit. Register 1 is the status register. It reports the abilities of the device and a link bit that is captured low. Every other register address reads as zero. While the PHY address of a frame matches, a chip-select output is held low. An inverted loopback output is held low whenever loopback is set.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame starts only if at least 32 consecutive ones were sampled on MDIO before the zero that begins the start code (01). After a shorter run of ones, the frame is ignored: there is no drive and no register change.
- R2: The opcode 10 reads and the opcode 01 writes. A frame with opcode 00 or 11 is dropped without any drive or write.
- R3: On a read, the slave leaves MDIO undriven during the first turnaround bit and drives 0 during the second. It then drives data bits 15 down to 0, one per MDC cycle, and releases the line after bit 0.
- R4: A control read returns loopback on bit 14, speed on bit 13 (always 1), power down on bit 11, isolate on bit 10, duplex on bit 8 and collision test on bit 7. Bits 15, 12, 9 and 6..0 read 0, and writes to them are ignored.
- R5: A control write to bits 14, 11, 10, 8 and 7 updates the loopback, power-down, isolate, full-duplex and collision-test outputs. The lpbk_no output is the inverse of loopback.
- R6: After reset, isolate equals the inverse of local_strap_i. All other writable control bits reset to 0.
- R7: A control write with bit 15 set returns the control register to its reset values, whatever the other data bits are. Bit 15 then reads 0.
- R8: A status read returns 1 on bits 14 and 13, the latched link bit on bit 2, and 0 on all other bits.
- R9: The latched link bit is cleared on any cycle where link_up_i is low. It stays cleared until the status register is read, and that read reloads it with the live link_up_i. Its reset value is 0.
- R10: cs_no goes low after the last PHY-address bit of a matching frame and returns high at the end of the frame. A frame for another address never drives MDIO and never changes a register.
- R11: A read of any register address other than 0 and 1 returns 0x0000.
- R12: Asserting rst_ni low returns both registers to their reset values at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc_i | input | 1 | Management clock; MDIO is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mdio_i | input | 1 | MDIO input value |
| mdio_o | output | 1 | MDIO value driven by the slave |
| mdio_oe_o | output | 1 | High while the slave drives MDIO |
| phy_addr_i | input | 5 | Strapped PHY address |
| local_strap_i | input | 1 | Strap; low makes isolate default to 1 |
| link_up_i | input | 1 | Live link state |
| cs_no | output | 1 | Low while a frame addressed to this PHY is in progress |
| lpbk_no | output | 1 | Low while loopback is set |
| ctl_loopback_o | output | 1 | Control bit 14 |
| ctl_power_down_o | output | 1 | Control bit 11 |
| ctl_isolate_o | output | 1 | Control bit 10 |
| ctl_full_duplex_o | output | 1 | Control bit 8 |
| ctl_col_test_o | output | 1 | Control bit 7 |

## Verification
A wrong frame-parser state shows up within the same frame. The slave may drive MDIO on a frame for another address, miss the turnaround window, or shift data one bit off. Any of these corrupts the word the bench reassembles from MDIO, or sets the enable when it should be low. A wrong register state shows on the control outputs one MDC cycle after the write's last data bit, and on the next read of that address. A link latch that fails to capture a low level, or that reloads at the wrong time, is exposed by two back-to-back status reads after a link drop.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;

  typedef enum logic [2:0] {
    S_IDLE, S_ST, S_OP, S_PHY, S_REG, S_TA, S_DATA
  } mdio_state_e;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  localparam logic [ADDR_W-1:0] CTL_ADDR = 5'd0;
  localparam logic [ADDR_W-1:0] STS_ADDR = 5'd1;

  // control bit positions
  localparam int B_RST = 15;
  localparam int B_LB  = 14;
  localparam int B_SPD = 13;
  localparam int B_PD  = 11;
  localparam int B_ISO = 10;
  localparam int B_DUP = 8;
  localparam int B_COL = 7;
  // status bit positions
  localparam int B_FDX = 14;
  localparam int B_HDX = 13;
  localparam int B_LNK = 2;
endpackage

// File: rtl/mdio_pre_det.sv
module mdio_pre_det #(
  parameter int PRE_LEN = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic bit_i,
  output logic pre_ok_o
);
  localparam int CW = $clog2(PRE_LEN + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i || !bit_i)           cnt_q <= '0;
    else if (cnt_q != CW'(PRE_LEN))     cnt_q <= cnt_q + 1'b1;
  end

  assign pre_ok_o = (cnt_q == CW'(PRE_LEN));

  a_r1_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(PRE_LEN));
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_mgmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mdio_i,
  input  logic              pre_ok_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              pre_clr_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              cs_no,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              rd_req_o,
  output logic              wr_req_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] FLD_LAST  = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  mdio_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-2:0] sh_q;
  logic [DATA_W-1:0] tx_q;
  logic              is_rd_q, match_q, oe_q, out_q, cs_nq;
  logic [ADDR_W-1:0] reg_q;
  logic              serve;

  assign serve = is_rd_q && match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      is_rd_q <= 1'b0;
      match_q <= 1'b0;
      oe_q    <= 1'b0;
      out_q   <= 1'b0;
      cs_nq   <= 1'b1;
      reg_q   <= '0;
    end else begin
      sh_q <= {sh_q[DATA_W-3:0], mdio_i};
      unique case (state_q)
        S_IDLE: if (pre_ok_i && !mdio_i) state_q <= S_ST;
        S_ST: begin
          cnt_q   <= '0;
          state_q <= mdio_i ? S_OP : S_IDLE;
        end
        S_OP: begin
          if (cnt_q == '0) cnt_q <= 1'b1;
          else begin
            cnt_q <= '0;
            if ({sh_q[0], mdio_i} == OP_RD) begin
              is_rd_q <= 1'b1;
              state_q <= S_PHY;
            end else if ({sh_q[0], mdio_i} == OP_WR) begin
              is_rd_q <= 1'b0;
              state_q <= S_PHY;
            end else state_q <= S_IDLE;
          end
        end
        S_PHY: begin
          if (cnt_q == FLD_LAST) begin
            match_q <= ({sh_q[ADDR_W-2:0], mdio_i} == phy_addr_i);
            cs_nq   <= ({sh_q[ADDR_W-2:0], mdio_i} != phy_addr_i);
            cnt_q   <= '0;
            state_q <= S_REG;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_REG: begin
          if (cnt_q == FLD_LAST) begin
            reg_q   <= {sh_q[ADDR_W-2:0], mdio_i};
            cnt_q   <= '0;
            state_q <= S_TA;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_TA: begin
          if (cnt_q == '0) begin
            cnt_q <= 1'b1;
            if (serve) begin
              oe_q  <= 1'b1;
              out_q <= 1'b0;
              tx_q  <= rd_data_i;
            end
          end else begin
            cnt_q   <= '0;
            state_q <= S_DATA;
            if (serve) begin
              out_q <= tx_q[DATA_W-1];
              tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
            end
          end
        end
        S_DATA: begin
          if (serve) begin
            out_q <= tx_q[DATA_W-1];
            tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
          end
          if (cnt_q == DATA_LAST) begin
            oe_q    <= 1'b0;
            cs_nq   <= 1'b1;
            match_q <= 1'b0;
            cnt_q   <= '0;
            state_q <= S_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign pre_clr_o  = (state_q != S_IDLE);
  assign mdio_o     = out_q;
  assign mdio_oe_o  = oe_q;
  assign cs_no      = cs_nq;
  assign reg_addr_o = reg_q;
  assign rd_req_o   = (state_q == S_TA) && (cnt_q == '0) && serve;
  assign wr_req_o   = (state_q == S_DATA) && (cnt_q == DATA_LAST) && !is_rd_q && match_q;
  assign wr_data_o  = {sh_q, mdio_i};

  a_r1_no_start_wo_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && !pre_ok_i) |=> state_q == S_IDLE);
  a_r2_bad_op_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_OP && cnt_q == 1'b1 && sh_q[0] == mdio_i) |=> state_q == S_IDLE);
  a_r3_ta_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_TA && cnt_q == '0) |-> !mdio_oe_o);
  a_r10_drive_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_oe_o |-> !cs_no);
  a_r10_cs_high_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE) |-> cs_no);
endmodule

// File: rtl/mdio_reg_file.sv
module mdio_reg_file
  import mdio_mgmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              local_strap_i,
  input  logic              link_up_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              rd_req_i,
  input  logic              wr_req_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              lb_o,
  output logic              pd_o,
  output logic              iso_o,
  output logic              dup_o,
  output logic              col_o
);
  logic lb_q, pd_q, iso_q, dup_q, col_q, link_q;
  logic ctl_wr, sts_rd;

  assign ctl_wr = wr_req_i && (reg_addr_i == CTL_ADDR);
  assign sts_rd = rd_req_i && (reg_addr_i == STS_ADDR);

  // isolate default follows the strap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lb_q <= 1'b0; pd_q <= 1'b0; iso_q <= ~local_strap_i; dup_q <= 1'b0; col_q <= 1'b0;
    end else if (ctl_wr) begin
      if (wr_data_i[B_RST]) begin
        lb_q <= 1'b0; pd_q <= 1'b0; iso_q <= ~local_strap_i; dup_q <= 1'b0; col_q <= 1'b0;
      end else begin
        lb_q  <= wr_data_i[B_LB];
        pd_q  <= wr_data_i[B_PD];
        iso_q <= wr_data_i[B_ISO];
        dup_q <= wr_data_i[B_DUP];
        col_q <= wr_data_i[B_COL];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     link_q <= 1'b0;
    else if (sts_rd) link_q <= link_up_i;
    else             link_q <= link_q & link_up_i;
  end

  always_comb begin
    rd_data_o = '0;
    if (reg_addr_i == CTL_ADDR) begin
      rd_data_o[B_LB]  = lb_q;
      rd_data_o[B_SPD] = 1'b1;
      rd_data_o[B_PD]  = pd_q;
      rd_data_o[B_ISO] = iso_q;
      rd_data_o[B_DUP] = dup_q;
      rd_data_o[B_COL] = col_q;
    end else if (reg_addr_i == STS_ADDR) begin
      rd_data_o[B_FDX] = 1'b1;
      rd_data_o[B_HDX] = 1'b1;
      rd_data_o[B_LNK] = link_q;
    end
  end

  assign lb_o  = lb_q;
  assign pd_o  = pd_q;
  assign iso_o = iso_q;
  assign dup_o = dup_q;
  assign col_o = col_q;

  a_r9_link_latch_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_up_i && !sts_rd) |=> !link_q);
  a_r9_read_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_rd |=> (link_q == $past(link_up_i)));
  a_r7_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && wr_data_i[B_RST]) |=> (!lb_q && !pd_q && !dup_q && !col_q && iso_q == ~local_strap_i));
  a_r11_other_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i != CTL_ADDR && reg_addr_i != STS_ADDR) |-> rd_data_o == '0);
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              mdc_i,
  input  logic              rst_ni,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic              local_strap_i,
  input  logic              link_up_i,
  output logic              cs_no,
  output logic              lpbk_no,
  output logic              ctl_loopback_o,
  output logic              ctl_power_down_o,
  output logic              ctl_isolate_o,
  output logic              ctl_full_duplex_o,
  output logic              ctl_col_test_o
);
  logic              pre_ok, pre_clr, rd_req, wr_req;
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] rd_data, wr_data;

  mdio_pre_det #(.PRE_LEN(PRE_LEN)) u_pre (
    .clk_i(mdc_i), .rst_ni(rst_ni), .clr_i(pre_clr), .bit_i(mdio_i), .pre_ok_o(pre_ok)
  );

  mdio_frame_fsm u_fsm (
    .clk_i(mdc_i), .rst_ni(rst_ni), .mdio_i(mdio_i), .pre_ok_i(pre_ok),
    .phy_addr_i(phy_addr_i), .rd_data_i(rd_data), .pre_clr_o(pre_clr),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .cs_no(cs_no), .reg_addr_o(reg_addr),
    .rd_req_o(rd_req), .wr_req_o(wr_req), .wr_data_o(wr_data)
  );

  mdio_reg_file u_regs (
    .clk_i(mdc_i), .rst_ni(rst_ni), .local_strap_i(local_strap_i), .link_up_i(link_up_i),
    .reg_addr_i(reg_addr), .rd_req_i(rd_req), .wr_req_i(wr_req), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .lb_o(ctl_loopback_o), .pd_o(ctl_power_down_o),
    .iso_o(ctl_isolate_o), .dup_o(ctl_full_duplex_o), .col_o(ctl_col_test_o)
  );

  assign lpbk_no = ~ctl_loopback_o;

  a_r5_lpbk_pin: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    $rose(ctl_loopback_o) |-> $fell(lpbk_no));
endmodule

// File: tb/mdio_mgmt_slave_tb_top.sv
module mdio_mgmt_slave_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mdio_i = 1'b0;
  logic       mdio_o, mdio_oe_o, cs_no, lpbk_no;
  logic [4:0] phy_addr_i = 5'h0B;
  logic       local_strap_i = 1'b1;
  logic       link_up_i = 1'b1;
  logic       lb, pd, iso, dup, col;

  int n_chk = 0, n_bad = 0;
  logic [15:0] exp_q[$], got_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  mdio_mgmt_slave dut_i (
    .mdc_i(clk), .rst_ni(rst_ni), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o),
    .phy_addr_i(phy_addr_i), .local_strap_i(local_strap_i), .link_up_i(link_up_i),
    .cs_no(cs_no), .lpbk_no(lpbk_no), .ctl_loopback_o(lb), .ctl_power_down_o(pd),
    .ctl_isolate_o(iso), .ctl_full_duplex_o(dup), .ctl_col_test_o(col)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] ctl_word(input logic l, p, i, d, c);
    return {1'b0, l, 1'b1, 1'b0, p, i, 1'b0, d, c, 7'b0};
  endfunction

  // one frame; samples at negedges, each reflecting the previous rising edge
  task automatic frame(input int pre_n, input logic [1:0] op, input logic [4:0] pa, ra,
                       input logic [15:0] wd, output logic [15:0] got,
                       output logic ta_ok, output logic any_oe, output logic cs_low);
    logic [31:0] v;
    v = {2'b01, op, pa, ra, (op == 2'b01) ? 2'b10 : 2'b11, (op == 2'b01) ? wd : 16'hFFFF};
    got = '0; ta_ok = 1'b1; any_oe = 1'b0; cs_low = 1'b0;
    for (int k = 0; k < pre_n; k++) begin
      @(negedge clk); mdio_i = 1'b1;
    end
    for (int i = 0; i <= 32; i++) begin
      @(negedge clk);
      any_oe |= mdio_oe_o;
      if (cs_no == 1'b0) cs_low = 1'b1;
      if (i == 14 && mdio_oe_o !== 1'b0) ta_ok = 1'b0;
      if (i == 15 && (mdio_oe_o !== 1'b1 || mdio_o !== 1'b0)) ta_ok = 1'b0;
      if (i == 32 && mdio_oe_o !== 1'b0) ta_ok = 1'b0;
      if (i >= 16 && i <= 31) got[31-i] = mdio_o;
      if (i < 32) mdio_i = v[31-i];
    end
    mdio_i = 1'b0;
  endtask

  task automatic wr(input logic [4:0] pa, ra, input logic [15:0] d);
    logic [15:0] g; logic t, a, c;
    frame(32, 2'b01, pa, ra, d, g, t, a, c);
    repeat (2) @(negedge clk);
  endtask

  // driver: pushes expected value, then the captured word for the monitor
  task automatic rd(input logic [4:0] ra, input logic [15:0] exp, input string tag);
    logic [15:0] g; logic t, a, c;
    exp_q.push_back(exp); tag_q.push_back(tag);
    frame(32, 2'b10, phy_addr_i, ra, 16'h0, g, t, a, c);
    got_q.push_back(g);
    chk({tag, " R3 turnaround/release"}, {15'b0, t}, 16'h1);
    chk({tag, " R10 cs low on match"}, {15'b0, c}, 16'h1);
    repeat (2) @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (got_q.size() > 0)
        chk(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
    end
  end

  task automatic finish_run();
    wait (got_q.size() == 0);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    logic [15:0] g; logic t, a, c;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R12 R6 reset state, strap high
    chk("R12 reset outputs", {11'b0, cs_no, lpbk_no, mdio_oe_o, iso, lb}, {11'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0});
    rd(5'd0, 16'h2000, "R4 R6 ctl default");
    rd(5'd1, 16'h6000, "R8 R9 status reset latch 0");
    rd(5'd1, 16'h6004, "R9 status reload after read");
    // R5 write all control bits plus read-only junk (bits 12,9,0)
    wr(phy_addr_i, 5'd0, 16'h4000 | 16'h0800 | 16'h0400 | 16'h0100 | 16'h0080 | 16'h1201);
    chk("R5 ctl outputs", {10'b0, lb, pd, iso, dup, col, lpbk_no}, {10'b0, 6'b111110});
    rd(5'd0, ctl_word(1, 1, 1, 1, 1), "R4 ctl readback");
    wr(phy_addr_i, 5'd0, 16'h0100);
    chk("R5 partial write", {11'b0, lb, pd, iso, dup, col}, {11'b0, 5'b00010});
    chk("R5 lpbk_no high", {15'b0, lpbk_no}, 16'h1);
    // R9 link drop and recovery
    @(negedge clk); link_up_i = 1'b0;
    repeat (3) @(negedge clk); link_up_i = 1'b1;
    rd(5'd1, 16'h6000, "R9 latched low");
    rd(5'd1, 16'h6004, "R9 reloaded high");
    // R7 self-clearing reset bit
    wr(phy_addr_i, 5'd0, 16'h4D80);
    wr(phy_addr_i, 5'd0, 16'hCD80);
    chk("R7 ctl reset outputs", {11'b0, lb, pd, iso, dup, col}, 16'h0);
    rd(5'd0, 16'h2000, "R7 ctl after self-clear");
    // R11 other addresses
    rd(5'd5, 16'h0000, "R11 addr 5");
    rd(5'd31, 16'h0000, "R11 addr 31");
    // R10 other PHY address
    wr(5'h0C, 5'd0, 16'h4000);
    chk("R10 foreign write ignored", {15'b0, lb}, 16'h0);
    frame(32, 2'b10, 5'h0C, 5'd0, 16'h0, g, t, a, c);
    chk("R10 foreign read no drive", {14'b0, a, c}, 16'h0);
    // R1 short preamble
    frame(31, 2'b01, phy_addr_i, 5'd0, 16'h4000, g, t, a, c);
    repeat (2) @(negedge clk);
    chk("R1 short preamble write ignored", {15'b0, lb}, 16'h0);
    frame(31, 2'b10, phy_addr_i, 5'd1, 16'h0, g, t, a, c);
    chk("R1 short preamble read no drive", {14'b0, a, c}, 16'h0);
    // R2 invalid opcodes
    frame(32, 2'b11, phy_addr_i, 5'd0, 16'h0, g, t, a, c);
    chk("R2 opcode 11 no drive", {15'b0, a}, 16'h0);
    frame(32, 2'b00, phy_addr_i, 5'd0, 16'h4000, g, t, a, c);
    repeat (2) @(negedge clk);
    chk("R2 opcode 00 no write", {15'b0, lb}, 16'h0);
    rd(5'd0, 16'h2000, "R2 valid read after bad op");
    // R12 R6 reset with strap low, after setting loopback
    wr(phy_addr_i, 5'd0, 16'h4000);
    chk("R5 loopback set", {14'b0, lb, lpbk_no}, 16'h2);
    local_strap_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R12 R6 reset strap low", {13'b0, lb, iso, lpbk_no}, 16'h3);
    rd(5'd0, 16'h2400, "R6 isolate default from strap");
    wr(phy_addr_i, 5'd0, 16'h8000);
    chk("R7 self-clear keeps strap default", {15'b0, iso}, 16'h1);
    finish_run();
  end
endmodule